// File: doc/BRIEF.md
# Automatic Receiver Detect Controller

This block manages one side of a differential repeater lane group. It decides whether a far-end receiver is attached to a differential output and sets the matching input termination. In automatic operation it fires a one-cycle probe strobe, samples the load-sense results of the two legs of the pair a fixed number of cycles later, and either switches the input to 50 ohm with the lane marked active or waits a programmed number of millisecond ticks and probes again. The impedance measurement is outside the block: each leg reports a pass or fail bit.

The detect pin selects the retry policy. When it is low, retries continue until a receiver is found. When it is high, the number of retries is capped at a time budget, and a fresh low-to-high transition on the pin starts a new sequence. A manual-enable input bypasses the sequencer, and then the detect pin sets the termination and lane state directly. A cable-absent input overrides everything and forces power-down. A qualified (long enough) power-down pulse starts a new detection sequence when it ends. A pulse that is too short is treated as a glitch.

Top module: `rxdet_ctrl`

## Requirements
- R1: While `rst` is high, `probe`, `term_50`, `lane_active` and `pwr_down` are all low. With no other stimulus, the first probe strobe is visible in the first cycle after the first clock edge at which `rst` is low.
- R2: `probe` is high for exactly one cycle. The load-sense bits are sampled only at the clock edge that ends the SENSE_DLY-th cycle after the strobe cycle. Values present at any other edge have no effect.
- R3: A detection succeeds only when `leg_pass` equals 2'b11 (bit 0 is the positive leg, bit 1 the negative leg) at the sampling edge. On success, `term_50` and `lane_active` go high in the cycle after that edge. Any other value counts as no receiver, and both stay low.
- R4: After a failed probe, the next strobe appears in the cycle after the INTERVAL_MS-th `ms_tick` received while waiting. Earlier ticks produce no strobe.
- R5: With `det_pin` low in automatic operation, failed probes are retried without limit.
- R6: With `det_pin` high in automatic operation, probing stops after LIMIT_MS/INTERVAL_MS failed probes. Further ticks give no strobe, and a fall of `det_pin` alone does not resume probing.
- R7: In automatic operation with no receiver found, a rise of `det_pin` restarts the sequence. The new strobe is visible in the third cycle after the rise is applied, and the retry budget is refilled.
- R8: With `man_en` high, the cycle after an input change shows `term_50` = `lane_active` = `det_pin`. No probe strobe is issued, whatever ticks arrive.
- R9: When `man_en` falls, automatic detection restarts. A strobe is visible in the third cycle after the fall is applied.
- R10: From the cycle after `cable_absent` goes high, and for as long as it stays high, `pwr_down` is high and `probe`, `term_50` and `lane_active` are low.
- R11: When a `cable_absent` pulse of at least PRES_MIN_CYC cycles ends, the controller drops the termination and restarts detection. A strobe is visible in the third cycle after the input falls.
- R12: A `cable_absent` pulse shorter than PRES_MIN_CYC cycles does not restart detection. A receiver already found is restored from the cycle after the pulse ends, and no new strobe follows.
- R13: Once a receiver is found, no further probe strobes are issued until a restart condition occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cable_absent | input | 1 | High when no cable is present; requests power-down |
| man_en | input | 1 | High selects manual termination control |
| det_pin | input | 1 | Manual termination select, or retry policy in automatic operation |
| leg_pass | input | 2 | Load-sense pass per leg, bit 0 positive, bit 1 negative |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| probe | output | 1 | One-cycle strobe that starts a load probe |
| term_50 | output | 1 | High selects 50 ohm input termination, low high impedance |
| lane_active | output | 1 | High when the lane output is enabled |
| pwr_down | output | 1 | High while the side is held in power saving |

## Verification
All control inputs pass through one register stage. Power-down, manual termination and the result of a sampled probe therefore appear in the cycle after the causing edge. Restarts take two more edges (an initialise state, then the strobe state), so a strobe follows three cycles after the input change. The bench drives every input just after a falling edge and reads outputs at the following falling edges. Each expectation is tied to an exact falling-edge count. Windowed load-sense pulses, placed one edge early and then on the correct edge, pin the sampling point. Tick-by-tick stepping confirms that the strobe arrives on exactly the INTERVAL_MS-th tick.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [2:0] {
        RD_INIT   = 3'd0,
        RD_PROBE  = 3'd1,
        RD_SENSE  = 3'd2,
        RD_WAIT   = 3'd3,
        RD_FOUND  = 3'd4,
        RD_STOP   = 3'd5,
        RD_MANUAL = 3'd6
    } rd_state_e;

    // registered view of the control pins
    typedef struct packed {
        logic pres;      // cable absent, registered
        logic man;       // manual enable, registered
        logic det;       // detect pin, registered
        logic det_rise;  // detect pin low-to-high seen this cycle
    } rd_ctl_t;

    typedef struct packed {
        logic probe;
        logic term50;
        logic lane;
        logic pdown;
    } rd_out_t;

    // a receiver counts only when both legs see a valid load
    function automatic logic pair_ok(input logic [1:0] legs);
        return legs[0] & legs[1];
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rxd_in_sync.sv
module rxd_in_sync
    import rxd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pres_in,
    input  logic    man_in,
    input  logic    det_in,
    output rd_ctl_t ctl
);

    logic pres_q, man_q, det_q, det_q2;

    always_ff @(posedge clk) begin
        if (rst) begin
            pres_q <= 1'b0;
            man_q  <= 1'b0;
            det_q  <= 1'b0;
            det_q2 <= 1'b0;
        end else begin
            pres_q <= pres_in;
            man_q  <= man_in;
            det_q  <= det_in;
            det_q2 <= det_q;
        end
    end

    always_comb begin
        ctl.pres     = pres_q;
        ctl.man      = man_q;
        ctl.det      = det_q;
        ctl.det_rise = det_q & ~det_q2;
    end

endmodule

// File: rtl/rxd_pres_filter.sv
module rxd_pres_filter #(
    parameter int unsigned PRES_MIN_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic pres_q,
    output logic rearm
);

    localparam int unsigned PW = rxd_pkg::cnt_width(PRES_MIN_CYC + 1);
    localparam logic [PW-1:0] PMIN_V = PW'(PRES_MIN_CYC);

    logic [PW-1:0] high_cnt;

    // counts cycles of registered presence high, saturating at the minimum
    always_ff @(posedge clk) begin
        if (rst) begin
            high_cnt <= '0;
        end else if (pres_q) begin
            if (high_cnt != PMIN_V) high_cnt <= high_cnt + 1'b1;
        end else begin
            high_cnt <= '0;
        end
    end

    // first low cycle after a long enough pulse
    assign rearm = ~pres_q & (high_cnt == PMIN_V);

endmodule

// File: rtl/rxd_retry_timer.sv
module rxd_retry_timer #(
    parameter int unsigned INTERVAL_MS = 12,
    parameter int unsigned MAX_PROBES  = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic wait_en,
    input  logic ms_tick,
    input  logic probe_fire,
    output logic due,
    output logic spent
);

    localparam int unsigned TW = rxd_pkg::cnt_width(INTERVAL_MS);
    localparam int unsigned NW = rxd_pkg::cnt_width(MAX_PROBES + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(INTERVAL_MS - 1);
    localparam logic [NW-1:0] PROBE_CAP = NW'(MAX_PROBES);

    logic [TW-1:0] tick_cnt;
    logic [NW-1:0] probe_cnt;

    assign due   = wait_en & ms_tick & (tick_cnt == TICK_LAST);
    assign spent = (probe_cnt == PROBE_CAP);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tick_cnt <= '0;
        end else if (due) begin
            tick_cnt <= '0;
        end else if (wait_en && ms_tick) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            probe_cnt <= '0;
        end else if (probe_fire && !spent) begin
            probe_cnt <= probe_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rxd_fsm.sv
module rxd_fsm
    import rxd_pkg::*;
#(
    parameter int unsigned SENSE_DLY = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  rd_ctl_t    ctl,
    input  logic       rearm,
    input  logic       due,
    input  logic       spent,
    input  logic [1:0] legs,
    output logic       clr,
    output logic       wait_en,
    output logic       probe_fire,
    output rd_out_t    outs
);

    localparam int unsigned SW = cnt_width(SENSE_DLY);
    localparam logic [SW-1:0] SENSE_LAST = SW'(SENSE_DLY - 1);

    rd_state_e st, nxt;
    logic [SW-1:0] sense_cnt;
    logic sense_done;
    logic run;
    logic found;

    assign run        = ~ctl.pres & ~ctl.man;
    assign sense_done = (sense_cnt == SENSE_LAST);

    always_comb begin
        nxt = st;
        if (ctl.pres) begin
            nxt = st;
        end else if (ctl.man) begin
            nxt = RD_MANUAL;
        end else if (st == RD_MANUAL || rearm || (ctl.det_rise && st != RD_FOUND)) begin
            nxt = RD_INIT;
        end else begin
            unique case (st)
                RD_INIT:  nxt = RD_PROBE;
                RD_PROBE: nxt = RD_SENSE;
                RD_SENSE: begin
                    if (sense_done) begin
                        if (pair_ok(legs))       nxt = RD_FOUND;
                        else if (ctl.det && spent) nxt = RD_STOP;
                        else                     nxt = RD_WAIT;
                    end
                end
                RD_WAIT:  if (due) nxt = RD_PROBE;
                RD_FOUND: nxt = RD_FOUND;
                RD_STOP:  nxt = RD_STOP;
                default:  nxt = RD_INIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= RD_INIT;
        else     st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || st != RD_SENSE) begin
            sense_cnt <= '0;
        end else if (run && !sense_done) begin
            sense_cnt <= sense_cnt + 1'b1;
        end
    end

    assign clr        = (st == RD_INIT);
    assign wait_en    = (st == RD_WAIT) & run;
    assign probe_fire = (st == RD_PROBE) & run;
    assign found      = (st == RD_FOUND) & ~rearm;

    always_comb begin
        outs.probe  = probe_fire;
        outs.term50 = ~ctl.pres & (ctl.man ? ctl.det : found);
        outs.lane   = outs.term50;
        outs.pdown  = ctl.pres;
    end

endmodule

// File: rtl/rxdet_ctrl.sv
module rxdet_ctrl
    import rxd_pkg::*;
#(
    parameter int unsigned INTERVAL_MS  = 12,
    parameter int unsigned LIMIT_MS     = 600,
    parameter int unsigned SENSE_DLY    = 4,
    parameter int unsigned PRES_MIN_CYC = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cable_absent,
    input  logic       man_en,
    input  logic       det_pin,
    input  logic [1:0] leg_pass,
    input  logic       ms_tick,
    output logic       probe,
    output logic       term_50,
    output logic       lane_active,
    output logic       pwr_down
);

    localparam int unsigned MAX_PROBES = (LIMIT_MS / INTERVAL_MS > 0) ? LIMIT_MS / INTERVAL_MS : 1;

    rd_ctl_t ctl;
    rd_out_t outs;
    logic rearm, due, spent, clr, wait_en, probe_fire;

    rxd_in_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .pres_in (cable_absent),
        .man_in  (man_en),
        .det_in  (det_pin),
        .ctl     (ctl)
    );

    rxd_pres_filter #(.PRES_MIN_CYC(PRES_MIN_CYC)) u_pres (
        .clk    (clk),
        .rst    (rst),
        .pres_q (ctl.pres),
        .rearm  (rearm)
    );

    rxd_retry_timer #(.INTERVAL_MS(INTERVAL_MS), .MAX_PROBES(MAX_PROBES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .wait_en    (wait_en),
        .ms_tick    (ms_tick),
        .probe_fire (probe_fire),
        .due        (due),
        .spent      (spent)
    );

    rxd_fsm #(.SENSE_DLY(SENSE_DLY)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .rearm      (rearm),
        .due        (due),
        .spent      (spent),
        .legs       (leg_pass),
        .clr        (clr),
        .wait_en    (wait_en),
        .probe_fire (probe_fire),
        .outs       (outs)
    );

    assign probe       = outs.probe;
    assign term_50     = outs.term50;
    assign lane_active = outs.lane;
    assign pwr_down    = outs.pdown;

endmodule

// File: rtl/rxdet_ctrl_chk.sv
module rxdet_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cable_absent,
    input logic       man_en,
    input logic       det_pin,
    input logic [1:0] leg_pass,
    input logic       probe,
    input logic       term_50,
    input logic       lane_active,
    input logic       pwr_down
);

    p_probe_single_r2: assert property (@(posedge clk) disable iff (rst)
        probe |=> !probe);

    p_pdown_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (!term_50 && !lane_active && !probe));

    p_pdown_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_down) |-> $past(cable_absent));

    p_manual_follow_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(man_en) && !pwr_down) |-> (term_50 == $past(det_pin)));

    p_both_legs_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(term_50) && !$past(pwr_down) && !$past(man_en))
            |-> ($past(leg_pass) == 2'b11));

    p_found_silent_r13: assert property (@(posedge clk) disable iff (rst)
        term_50 |-> !probe);

endmodule

bind rxdet_ctrl rxdet_ctrl_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .cable_absent (cable_absent),
    .man_en       (man_en),
    .det_pin      (det_pin),
    .leg_pass     (leg_pass),
    .probe        (probe),
    .term_50      (term_50),
    .lane_active  (lane_active),
    .pwr_down     (pwr_down)
);

// File: tb/test_rxdet_ctrl.sv
module test_rxdet_ctrl;

    localparam int CLK_T    = 10;
    localparam int IVL      = 3;
    localparam int LIM      = 12;
    localparam int SDLY     = 2;
    localparam int PMIN     = 5;
    localparam int MAXP     = LIM / IVL;

    logic clk = 1'b0;
    logic rst, cable_absent, man_en, det_pin, ms_tick;
    logic [1:0] leg_pass;
    logic probe, term_50, lane_active, pwr_down;

    int total = 0;
    int bad   = 0;

    rxdet_ctrl #(
        .INTERVAL_MS(IVL), .LIMIT_MS(LIM), .SENSE_DLY(SDLY), .PRES_MIN_CYC(PMIN)
    ) i_rxdet_ctrl (
        .clk(clk), .rst(rst), .cable_absent(cable_absent), .man_en(man_en),
        .det_pin(det_pin), .leg_pass(leg_pass), .ms_tick(ms_tick),
        .probe(probe), .term_50(term_50), .lane_active(lane_active), .pwr_down(pwr_down)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic nx();
        @(negedge clk);
    endtask

    // one tick pulse, then the strobe seen at the following falling edge
    task automatic tick_round(output logic seen);
        ms_tick = 1'b1;
        nx();
        ms_tick = 1'b0;
        seen = probe;
    endtask

    // tick until a strobe appears (t = ticks used, 99 if none in 10),
    // then walk the sense window; win selects the edge for a 2'b11 pulse
    task automatic round(input logic [1:0] lg, input int win,
                         output int t, output logic tm2, output logic tm3);
        logic s;
        leg_pass = lg;
        t = 99;
        tm2 = 1'b0;
        tm3 = 1'b0;
        for (int i = 1; i <= 10; i++) begin
            tick_round(s);
            if (s) begin
                t = i;
                break;
            end
        end
        if (t != 99) begin
            nx();
            leg_pass = (win == 1) ? 2'b11 : lg;
            nx();
            tm2 = term_50;
            leg_pass = (win == 2) ? 2'b11 : lg;
            nx();
            tm3 = term_50;
            leg_pass = lg;
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_T * 50000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        report();
        $finish;
    end

    initial begin
        int t;
        logic a, b, s;
        rst = 1'b1; cable_absent = 1'b0; man_en = 1'b0; det_pin = 1'b0;
        ms_tick = 1'b0; leg_pass = 2'b00;
        repeat (3) nx();
        chk("R1 reset probe", probe, 0);
        chk("R1 reset term", term_50, 0);
        chk("R1 reset lane", lane_active, 0);
        chk("R1 reset pdown", pwr_down, 0);
        rst = 1'b0;
        nx();
        chk("R1 first strobe", probe, 1);
        nx();
        chk("R2 strobe one cycle", probe, 0);
        nx(); nx();
        chk("R3 no load keeps hi-z", term_50, 0);

        // R4 tick-by-tick interval, R5 unlimited retries beyond the budget
        for (int r = 0; r < MAXP + 2; r++) begin
            for (int k = 1; k <= IVL; k++) begin
                tick_round(s);
                chk($sformatf("R4 R5 tick %0d round %0d", k, r), s, (k == IVL) ? 1 : 0);
            end
            nx(); nx(); nx();
        end

        // R3 single-leg passes are rejected
        round(2'b01, 0, t, a, b);
        chk("R3 leg0 only ticks", t, IVL);
        chk("R3 leg0 only term", b, 0);
        round(2'b10, 0, t, a, b);
        chk("R3 leg1 only term", b, 0);
        chk("R3 leg1 only lane", lane_active, 0);
        // R2 pass value one edge early is not sampled
        round(2'b00, 1, t, a, b);
        chk("R2 early window term", b, 0);
        // R2 R3 pass value on the sampling edge
        round(2'b00, 2, t, a, b);
        chk("R2 window ticks", t, IVL);
        chk("R3 term before result", a, 0);
        chk("R3 term after result", b, 1);
        chk("R3 lane after result", lane_active, 1);

        // R13 no probing once found
        for (int k = 0; k < 2 * IVL; k++) begin
            tick_round(s);
            chk("R13 found no strobe", s, 0);
        end
        chk("R13 term held", term_50, 1);

        // R12 short presence pulse
        cable_absent = 1'b1;
        nx();
        chk("R10 pdown high", pwr_down, 1);
        chk("R10 term low", term_50, 0);
        chk("R10 lane low", lane_active, 0);
        repeat (PMIN - 2) nx();
        cable_absent = 1'b0;
        nx();
        chk("R12 pdown released", pwr_down, 0);
        chk("R12 term restored", term_50, 1);
        for (int k = 0; k < IVL + 1; k++) begin
            tick_round(s);
            chk("R12 no restart strobe", s, 0);
        end

        // R11 qualified presence pulse
        cable_absent = 1'b1;
        repeat (PMIN) nx();
        chk("R10 pdown during long pulse", pwr_down, 1);
        cable_absent = 1'b0;
        nx();
        chk("R11 term dropped", term_50, 0);
        chk("R11 pdown released", pwr_down, 0);
        nx();
        chk("R11 no strobe yet", probe, 0);
        nx();
        chk("R11 restart strobe", probe, 1);
        nx(); nx(); nx();

        // R7 detect rise restarts, R6 limited budget
        det_pin = 1'b1;
        nx();
        chk("R7 no strobe at 1", probe, 0);
        nx();
        chk("R7 no strobe at 2", probe, 0);
        nx();
        chk("R7 restart strobe", probe, 1);
        nx(); nx(); nx();
        for (int r = 2; r <= MAXP; r++) begin
            round(2'b00, 0, t, a, b);
            chk($sformatf("R6 probe %0d within budget", r), t, IVL);
        end
        round(2'b00, 0, t, a, b);
        chk("R6 stopped after budget", t, 99);
        det_pin = 1'b0;
        nx();
        for (int k = 0; k < IVL + 1; k++) begin
            tick_round(s);
            chk("R6 fall does not resume", s, 0);
        end
        det_pin = 1'b1;
        nx(); nx(); nx();
        chk("R7 rearm strobe", probe, 1);
        nx(); nx(); nx();
        for (int r = 2; r <= MAXP; r++) begin
            round(2'b00, 0, t, a, b);
            chk("R6 R7 budget refilled", t, IVL);
        end
        round(2'b00, 0, t, a, b);
        chk("R6 stopped again", t, 99);

        // R8 manual control
        man_en = 1'b1;
        det_pin = 1'b0;
        nx();
        chk("R8 manual low term", term_50, 0);
        chk("R8 manual low lane", lane_active, 0);
        det_pin = 1'b1;
        nx();
        chk("R8 manual high term", term_50, 1);
        chk("R8 manual high lane", lane_active, 1);
        for (int k = 0; k < IVL + 1; k++) begin
            tick_round(s);
            chk("R8 manual no strobe", s, 0);
        end
        cable_absent = 1'b1;
        nx();
        chk("R10 override manual term", term_50, 0);
        chk("R10 override manual pdown", pwr_down, 1);
        cable_absent = 1'b0;
        nx();
        chk("R8 manual after glitch", term_50, 1);
        det_pin = 1'b0;
        nx();
        chk("R8 manual back low", term_50, 0);

        // R9 leave manual
        leg_pass = 2'b11;
        man_en = 1'b0;
        nx();
        chk("R9 term low on exit", term_50, 0);
        nx();
        chk("R9 no strobe yet", probe, 0);
        nx();
        chk("R9 restart strobe", probe, 1);
        nx(); nx();
        chk("R3 static pass pending", term_50, 0);
        nx();
        chk("R3 static pass found", term_50, 1);

        report();
        $finish;
    end

endmodule